// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block is the small address translation cache that sits in front of a memory management unit. Each lookup presents a virtual address, whether the access is a read or a write, and whether the requester runs in supervisor mode. A matching entry translates the address in the same cycle. The physical page number replaces the upper bits of the address, and the low 12 bits pass through unchanged. An access that the entry's permission bits do not allow produces a protection fault instead of an address.

When no entry matches, the block raises a miss. An external table walker then fetches the page table entry and loads it through the refill port. The block then answers the repeated lookup from its own storage. The eight entries are fully associative, and new entries replace old ones in round-robin order. A refill for a page number that is already present updates that entry in place, so a page number is never held twice. A flush input empties the whole cache on a context switch.

Top module: `tlb_perm`

## Requirements
- R1: After reset no entry is valid, so every valid lookup reports miss.
- R2: A valid lookup whose page number (address bits 31:12) matches a valid entry with the needed permission raises hit, and in the same cycle `paddr` equals {entry PPN, vaddr[11:0]}.
- R3: A valid lookup whose page number matches no valid entry raises miss, with hit and fault low and `paddr` zero.
- R4: hit, miss and fault are never high together, and all three are low while `req_valid` is low.
- R5: A matching entry with its supervisor bit set faults when `req_super` is 0 and hits when `req_super` is 1, if the read or write permission also allows the access.
- R6: A write (`req_write`=1) to an entry with its write bit clear faults, even in supervisor mode.
- R7: A read (`req_write`=0) to an entry with its read bit clear faults.
- R8: While fault is high, `paddr` is zero.
- R9: A refill whose page number is not yet held writes the slot under a round-robin pointer and advances the pointer. After all eight slots are used, each new refill evicts the oldest entry and leaves the others in place.
- R10: A refill whose page number matches a valid entry overwrites that entry's frame and permissions and does not advance the pointer, so no other entry is evicted.
- R11: A flush invalidates every entry at the next clock edge. A refill in the same cycle as a flush is dropped.
- R12: A refill becomes visible to lookups from the cycle after its clock edge. A lookup in the refill cycle itself still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = requester in supervisor mode |
| flush | input | 1 | Invalidate all entries |
| refill_valid | input | 1 | Load an entry at the next edge |
| refill_vpn | input | 20 | Virtual page number of the new entry |
| refill_ppn | input | 20 | Physical page number of the new entry |
| refill_rd | input | 1 | Read permitted |
| refill_wr | input | 1 | Write permitted |
| refill_sup | input | 1 | Supervisor-only page |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No matching entry |
| fault | output | 1 | Matching entry denies the access |
| paddr | output | 32 | Physical address, zero unless hit |

## Verification
A table of lookups runs against four loaded entries that differ in their permission bits. Each entry is probed with reads and writes in both privilege modes. This separates a wrong read/write bit selection from a wrong supervisor check. Offsets of 0x000 and 0xFFF, and page numbers that differ only in their top bits, show whether the offset passes through and whether the full page number is compared. Directed sequences fill all slots and then overflow them to show that the oldest entry is evicted. They also load a duplicate page number to show the update in place, and assert flush together with refill to show that flush wins.

// File: rtl/tlb_perm.sv
module tlb_perm #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   req_super,
  input  logic                   flush,
  input  logic                   refill_valid,
  input  logic [VA_W-PAGE_BITS-1:0] refill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] refill_ppn,
  input  logic                   refill_rd,
  input  logic                   refill_wr,
  input  logic                   refill_sup,
  output logic                   hit,
  output logic                   miss,
  output logic                   fault,
  output logic [PA_W-1:0]        paddr
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, rd_q, wr_q, sup_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] match, dup;
  logic [PPN_W-1:0]   sel_ppn;
  logic               sel_rd, sel_wr, sel_sup, any, perm_ok, dup_any;
  logic [IDX_W-1:0]   dup_idx, wr_idx;

  assign req_vpn = req_vaddr[VA_W-1:PAGE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == req_vpn);
    assign dup[g]   = vld_q[g] && (vpn_q[g] == refill_vpn);
  end

  always_comb begin
    sel_ppn = '0;
    sel_rd  = 1'b0;
    sel_wr  = 1'b0;
    sel_sup = 1'b0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_rd  = sel_rd  | rd_q[i];
        sel_wr  = sel_wr  | wr_q[i];
        sel_sup = sel_sup | sup_q[i];
      end
      if (dup[i]) dup_idx = IDX_W'(i);
    end
  end

  assign any     = |match;
  assign dup_any = |dup;
  assign perm_ok = !(sel_sup && !req_super) && (req_write ? sel_wr : sel_rd);
  assign hit     = req_valid && any && perm_ok;
  assign fault   = req_valid && any && !perm_ok;
  assign miss    = req_valid && !any;
  assign paddr   = hit ? {sel_ppn, req_vaddr[PAGE_BITS-1:0]} : '0;
  assign wr_idx  = dup_any ? dup_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (refill_valid) begin
      vld_q[wr_idx] <= 1'b1;
      if (!dup_any) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (refill_valid && !flush) begin
      vpn_q[wr_idx] <= refill_vpn;
      ppn_q[wr_idx] <= refill_ppn;
      rd_q[wr_idx]  <= refill_rd;
      wr_q[wr_idx]  <= refill_wr;
      sup_q[wr_idx] <= refill_sup;
    end
  end

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, fault}));
  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(hit || miss || fault));
  a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0));
  a_r10_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match) && $onehot0(dup));
  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  a_r9_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !flush && !dup_any) |=> vld_q[$past(ptr_q)] && (ptr_q != $past(ptr_q)));
  a_r10_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !flush && dup_any) |=> $stable(ptr_q) && $stable(vld_q));
endmodule

// File: tb/tlb_perm_tb.sv
module tlb_perm_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_super, flush;
  logic [31:0] req_vaddr;
  logic        refill_valid, refill_rd, refill_wr, refill_sup;
  logic [19:0] refill_vpn, refill_ppn;
  logic        hit, miss, fault;
  logic [31:0] paddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_perm u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .flush(flush),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_rd(refill_rd), .refill_wr(refill_wr), .refill_sup(refill_sup),
    .hit(hit), .miss(miss), .fault(fault), .paddr(paddr)
  );

  // {vaddr, write, super, hit, miss, fault, paddr}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {32'h0001_0123, 1'b0, 1'b0, 3'b100, 32'h0ABC_D123},  // R2
    {32'h0001_0FFF, 1'b1, 1'b0, 3'b100, 32'h0ABC_DFFF},  // R2
    {32'h0002_0000, 1'b0, 1'b0, 3'b100, 32'h1234_5000},  // R2
    {32'h0002_0004, 1'b1, 1'b0, 3'b001, 32'h0},          // R6 R8
    {32'h0003_0010, 1'b0, 1'b0, 3'b001, 32'h0},          // R7
    {32'h0003_0010, 1'b1, 1'b0, 3'b100, 32'h0077_7010},  // R7
    {32'h0004_0ABC, 1'b0, 1'b0, 3'b001, 32'h0},          // R5
    {32'h0004_0ABC, 1'b0, 1'b1, 3'b100, 32'hFFFF_FABC},  // R5
    {32'h0004_0ABC, 1'b1, 1'b1, 3'b100, 32'hFFFF_FABC},  // R5
    {32'h0005_0000, 1'b0, 1'b0, 3'b010, 32'h0},          // R3
    {32'h1001_0123, 1'b0, 1'b0, 3'b010, 32'h0},          // R3
    {32'h0002_0004, 1'b1, 1'b1, 3'b001, 32'h0}           // R6
  };
  string vtag [NV] = '{"R2", "R2", "R2", "R6", "R7", "R7",
                       "R5", "R5", "R5", "R3", "R3", "R6"};

  task automatic check(input string tag, input logic [2:0] exp_hmf, input logic [31:0] exp_pa);
    checks++;
    if ({hit, miss, fault} !== exp_hmf || paddr !== exp_pa) begin
      failures++;
      $display("FAIL %s: hit/miss/fault=%b pa=%h expected %b pa=%h",
               tag, {hit, miss, fault}, paddr, exp_hmf, exp_pa);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic sup);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_super = sup;
    #1;
  endtask

  task automatic load(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic r, input logic w, input logic s);
    @(negedge clk);
    refill_valid = 1'b1; refill_vpn = vpn; refill_ppn = ppn;
    refill_rd = r; refill_wr = w; refill_sup = s;
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_super = 1'b0;
    flush = 1'b0; refill_valid = 1'b0; refill_vpn = '0; refill_ppn = '0;
    refill_rd = 1'b0; refill_wr = 1'b0; refill_sup = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(32'h0000_0000, 1'b0, 1'b1); check("R1", 3'b010, 32'h0);
    look(32'h0001_0123, 1'b0, 1'b0); check("R1", 3'b010, 32'h0);

    load(20'h00010, 20'h0ABCD, 1, 1, 0);
    load(20'h00020, 20'h12345, 1, 0, 0);
    load(20'h00030, 20'h00777, 0, 1, 0);
    load(20'h00040, 20'hFFFFF, 1, 1, 1);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][68:37], VEC[i][36], VEC[i][35]);
      check(vtag[i], VEC[i][34:32], VEC[i][31:0]);
    end

    // R4: idle request gives no outputs
    look(32'h0001_0123, 1'b0, 1'b0);
    req_valid = 1'b0; #1;
    check("R4", 3'b000, 32'h0);

    // R12: refill not visible in its own cycle, visible after the edge
    @(negedge clk);
    refill_valid = 1'b1; refill_vpn = 20'h00050; refill_ppn = 20'h00055;
    refill_rd = 1; refill_wr = 1; refill_sup = 0;
    req_valid = 1'b1; req_vaddr = 32'h0005_0008; req_write = 1'b0; req_super = 1'b0;
    #1; check("R12", 3'b010, 32'h0);
    @(negedge clk);
    refill_valid = 1'b0; #1;
    check("R12", 3'b100, 32'h0005_5008);

    // R10: duplicate VPN updates in place
    load(20'h00010, 20'h0BEEF, 1, 0, 0);
    look(32'h0001_0040, 1'b0, 1'b0); check("R10", 3'b100, 32'h0BEE_F040);
    look(32'h0001_0040, 1'b1, 1'b0); check("R10", 3'b001, 32'h0);

    // R9: fill slots 5..7, then overflow evicts oldest (slot 0, then slot 1)
    load(20'h00060, 20'h00066, 1, 1, 0);
    load(20'h00070, 20'h00077, 1, 1, 0);
    load(20'h00080, 20'h00088, 1, 1, 0);
    look(32'h0001_0040, 1'b0, 1'b0); check("R10", 3'b100, 32'h0BEE_F040);
    load(20'h00090, 20'h00099, 1, 1, 0);
    look(32'h0001_0040, 1'b0, 1'b0); check("R9", 3'b010, 32'h0);
    look(32'h0002_0000, 1'b0, 1'b0); check("R9", 3'b100, 32'h1234_5000);
    look(32'h0009_0001, 1'b0, 1'b0); check("R9", 3'b100, 32'h0009_9001);
    look(32'h0005_0002, 1'b0, 1'b0); check("R9", 3'b100, 32'h0005_5002);
    load(20'h000A0, 20'h000AA, 1, 1, 0);
    look(32'h0002_0000, 1'b0, 1'b0); check("R9", 3'b010, 32'h0);
    look(32'h0003_0000, 1'b1, 1'b0); check("R9", 3'b100, 32'h0077_7000);
    look(32'h000A_0003, 1'b1, 1'b0); check("R9", 3'b100, 32'h000A_A003);

    // R11: flush wins over simultaneous refill
    @(negedge clk);
    flush = 1'b1; refill_valid = 1'b1; refill_vpn = 20'h000B0; refill_ppn = 20'h000BB;
    refill_rd = 1; refill_wr = 1; refill_sup = 0;
    @(negedge clk);
    flush = 1'b0; refill_valid = 1'b0;
    look(32'h0004_0000, 1'b0, 1'b1); check("R11", 3'b010, 32'h0);
    look(32'h0009_0000, 1'b0, 1'b0); check("R11", 3'b010, 32'h0);
    look(32'h000B_0000, 1'b0, 1'b0); check("R11", 3'b010, 32'h0);

    // R1 again: reset clears a loaded entry
    load(20'h000C0, 20'h000CC, 1, 1, 0);
    look(32'h000C_0000, 1'b0, 1'b0); check("R12", 3'b100, 32'h000C_C000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(32'h000C_0000, 1'b0, 1'b0); check("R1", 3'b010, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule